// File: doc/BRIEF.md
# Scanline Mode Timing Sequencer

This block sequences a raster display controller through its four per-line modes: object scan, pixel drawing, horizontal blank and vertical blank. It advances on every dot for which the dot clock enable is high. It keeps a dot counter inside the current line and a line counter inside the frame. It compares the line counter against a programmable compare line and keeps a counter of the lines on which the window layer was drawn.

Drawing has no fixed length. It lasts until the pixel pipeline has pushed a full visible line of pixels, and the pipeline reports each pushed pixel through a strobe. Horizontal blank then fills the line up to its fixed dot length. Lines past the visible area are vertical-blank lines. These lines end one dot later than usual, measured against the wrapped dot count. The block emits a one-cycle vertical-blank interrupt request and a one-cycle status interrupt request. The status request merges four maskable sources. The block also emits reset pulses that the pixel pipeline uses at the end of each line and at the start of vertical blank.

Top module: `scanline_seq`

## Requirements
- R1: After reset the outputs read as follows: mode is 2 (object scan), line is 0, dot is 0, coincidence is 0, window line is 0, and every pulse output is 0. The mode encoding is 0 for horizontal blank, 1 for vertical blank, 2 for object scan and 3 for drawing.
- R2: A clock with `dot_en_i` low changes no state, and all pulse outputs read 0 after it. An enabled dot increments `dot_o` by one, except where another requirement wraps or clears it.
- R3: In object scan, the enabled dot that brings the dot count to 80 switches the mode to drawing.
- R4: In drawing with `lcd_en_i` high, each enabled dot that has `px_push_i` high advances the pixel position by one. The first enabled dot after the position has reached 160 performs four actions: it clears the position, switches the mode to horizontal blank, pulses `line_rst_o`, and raises the horizontal-blank status source, which is bit 0.
- R5: The window line counter increments by one on the drawing-exit dot, and only if `win_drawn_i` is high on that dot. The counter clears on entry to vertical blank.
- R6: An enabled dot in drawing with `lcd_en_i` low, before the position has reached 160, resets the whole sequencer to the R1 state. No interrupt is raised.
- R7: In horizontal blank, the enabled dot that brings the dot count to 456 sets the dot count to (count minus 456) and increments the line. If the new line is below 144, the mode becomes object scan and the scan status source (bit 2) is raised.
- R8: Each time the line advances, `coinc_o` becomes (new line == `lyc_i`). On the wrap from line 153, the compared value is 154. If the two are equal, the coincidence status source (bit 3) is raised.
- R9: If the line reached at the end of horizontal blank is 144 or more, four things happen: the mode becomes vertical blank, `vblank_irq_o` pulses, `frame_rst_o` pulses, and the vertical-blank status source (bit 1) is raised.
- R10: In vertical blank, a line ends only on the enabled dot that brings the dot count above 456. The dot count is then reduced by 456. When the line would become 154, it becomes 0 instead, the mode returns to object scan, and the scan status source is raised.
- R11: `stat_irq_o` is a single-cycle pulse equal to the OR over all sources of (source raised AND its `stat_en_i` bit). When several sources are raised on one dot, only one pulse results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dot_en_i | input | 1 | Dot clock enable |
| lcd_en_i | input | 1 | Display enable |
| px_push_i | input | 1 | One pixel pushed by the pipeline |
| win_drawn_i | input | 1 | Window layer drawn on the current line |
| lyc_i | input | 8 | Compare line |
| stat_en_i | input | 4 | Status source enables: 0 hblank, 1 vblank, 2 scan, 3 coincidence |
| mode_o | output | 2 | Current mode |
| ly_o | output | 8 | Current line |
| dot_o | output | 10 | Dot count within the line |
| coinc_o | output | 1 | Line equals compare line |
| win_line_o | output | 8 | Window line counter |
| vblank_irq_o | output | 1 | Vertical-blank interrupt pulse |
| stat_irq_o | output | 1 | Merged status interrupt pulse |
| line_rst_o | output | 1 | End-of-drawing pipeline reset pulse |
| frame_rst_o | output | 1 | Start-of-vertical-blank pipeline reset pulse |

## Verification
The hardest state to reach is the frame wrap. Reaching it takes more than seventy thousand enabled dots through every visible line. At that point the coincidence test sees the pre-wrap value 154, and the dot count runs one past the line length. The stimulus keeps the dot enable and the pixel strobe mostly high with random gaps, so that at least one full frame completes. It sets the compare line to 154 shortly before the wrap. Display-off events are injected only once the mode is drawing, because the reset rule applies only there.

// File: rtl/scanline_pkg.sv
package scanline_pkg;
  typedef enum logic [1:0] {
    MODE_HBLANK = 2'd0,
    MODE_VBLANK = 2'd1,
    MODE_SCAN   = 2'd2,
    MODE_DRAW   = 2'd3
  } mode_e;

  localparam int unsigned SRC_HB    = 0;
  localparam int unsigned SRC_VB    = 1;
  localparam int unsigned SRC_SCAN  = 2;
  localparam int unsigned SRC_COINC = 3;
  localparam int unsigned NUM_SRC   = 4;
endpackage

// File: rtl/seq_line_trk.sv
module seq_line_trk #(
  parameter int unsigned TOTAL_LINES = 154,
  localparam int unsigned LINE_W = $clog2(TOTAL_LINES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              wrap_i,
  input  logic              clr_i,
  input  logic [LINE_W-1:0] lyc_i,
  output logic [LINE_W-1:0] ly_o,
  output logic [LINE_W-1:0] ly_inc_o,
  output logic              next_eq_o,
  output logic              coinc_o
);
  logic [LINE_W-1:0] ly_q;
  logic              coinc_q;

  assign ly_inc_o  = ly_q + LINE_W'(1);
  // compare uses the pre-wrap value
  assign next_eq_o = (ly_inc_o == lyc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ly_q    <= '0;
      coinc_q <= 1'b0;
    end else if (clr_i) begin
      ly_q    <= '0;
      coinc_q <= 1'b0;
    end else if (adv_i) begin
      ly_q    <= wrap_i ? '0 : ly_inc_o;
      coinc_q <= next_eq_o;
    end
  end

  assign ly_o    = ly_q;
  assign coinc_o = coinc_q;

  // R10
  ly_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ly_q < LINE_W'(TOTAL_LINES));

  // R8
  coinc_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(ly_q) && ly_q != '0) |-> (coinc_q == (ly_q == $past(lyc_i))));
endmodule

// File: rtl/seq_win_ctr.sv
module seq_win_ctr #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;

  // R5
  win_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt_q) |-> (cnt_q == '0 || cnt_q == $past(cnt_q) + W'(1)));
endmodule

// File: rtl/seq_stat_irq.sv
module seq_stat_irq #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ev_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  logic [N-1:0] masked;
  logic         irq_q;

  for (genvar g = 0; g < N; g++) begin : g_src
    assign masked[g] = ev_i[g] & en_i[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |masked;
  end

  assign irq_o = irq_q;

  // R11
  stat_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
endmodule

// File: rtl/scanline_seq.sv
module scanline_seq
  import scanline_pkg::*;
#(
  parameter int unsigned SCAN_DOTS   = 80,
  parameter int unsigned LINE_DOTS   = 456,
  parameter int unsigned VIS_PX      = 160,
  parameter int unsigned VIS_LINES   = 144,
  parameter int unsigned TOTAL_LINES = 154,
  localparam int unsigned DOT_W  = $clog2(2 * LINE_DOTS),
  localparam int unsigned LINE_W = $clog2(TOTAL_LINES + 1),
  localparam int unsigned X_W    = $clog2(VIS_PX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dot_en_i,
  input  logic              lcd_en_i,
  input  logic              px_push_i,
  input  logic              win_drawn_i,
  input  logic [LINE_W-1:0] lyc_i,
  input  logic [3:0]        stat_en_i,
  output logic [1:0]        mode_o,
  output logic [LINE_W-1:0] ly_o,
  output logic [DOT_W-1:0]  dot_o,
  output logic              coinc_o,
  output logic [LINE_W-1:0] win_line_o,
  output logic              vblank_irq_o,
  output logic              stat_irq_o,
  output logic              line_rst_o,
  output logic              frame_rst_o
);
  localparam logic [DOT_W-1:0]  SCAN_L  = DOT_W'(SCAN_DOTS);
  localparam logic [DOT_W-1:0]  LINE_L  = DOT_W'(LINE_DOTS);
  localparam logic [X_W-1:0]    VIS_X   = X_W'(VIS_PX);
  localparam logic [LINE_W-1:0] VIS_LY  = LINE_W'(VIS_LINES);
  localparam logic [LINE_W-1:0] TOT_LY  = LINE_W'(TOTAL_LINES);

  mode_e              mode_q, mode_d;
  logic [DOT_W-1:0]   dot_q, dot_d, dot_inc;
  logic [X_W-1:0]     x_q, x_d;
  logic               vb_q, lr_q, fr_q;
  logic               vb_d, lr_d, fr_d;
  logic               adv, wrap, seq_clr, win_inc, win_clr;
  logic [NUM_SRC-1:0] ev;
  logic [LINE_W-1:0]  ly, ly_inc;
  logic               next_eq;

  assign dot_inc = dot_q + DOT_W'(1);

  always_comb begin
    mode_d  = mode_q;
    dot_d   = dot_q;
    x_d     = x_q;
    adv     = 1'b0;
    wrap    = 1'b0;
    seq_clr = 1'b0;
    win_inc = 1'b0;
    win_clr = 1'b0;
    ev      = '0;
    vb_d    = 1'b0;
    lr_d    = 1'b0;
    fr_d    = 1'b0;
    if (dot_en_i) begin
      dot_d = dot_inc;
      unique case (mode_q)
        MODE_SCAN: begin
          if (dot_inc >= SCAN_L) mode_d = MODE_DRAW;
        end
        MODE_DRAW: begin
          if (x_q >= VIS_X) begin
            x_d        = '0;
            mode_d     = MODE_HBLANK;
            ev[SRC_HB] = 1'b1;
            win_inc    = win_drawn_i;
            lr_d       = 1'b1;
          end else if (lcd_en_i) begin
            x_d = x_q + X_W'(px_push_i);
          end else begin
            seq_clr = 1'b1;
            mode_d  = MODE_SCAN;
            dot_d   = '0;
            x_d     = '0;
          end
        end
        MODE_HBLANK: begin
          if (dot_inc >= LINE_L) begin
            dot_d         = dot_inc - LINE_L;
            adv           = 1'b1;
            ev[SRC_COINC] = next_eq;
            if (ly_inc >= VIS_LY) begin
              mode_d     = MODE_VBLANK;
              ev[SRC_VB] = 1'b1;
              vb_d       = 1'b1;
              fr_d       = 1'b1;
              win_clr    = 1'b1;
            end else begin
              mode_d       = MODE_SCAN;
              ev[SRC_SCAN] = 1'b1;
            end
          end
        end
        MODE_VBLANK: begin
          // vblank lines end one dot later
          if (dot_inc > LINE_L) begin
            dot_d         = dot_inc - LINE_L;
            adv           = 1'b1;
            ev[SRC_COINC] = next_eq;
            if (ly_inc == TOT_LY) begin
              wrap         = 1'b1;
              mode_d       = MODE_SCAN;
              ev[SRC_SCAN] = 1'b1;
            end
          end
        end
        default: mode_d = MODE_SCAN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_SCAN;
      dot_q  <= '0;
      x_q    <= '0;
      vb_q   <= 1'b0;
      lr_q   <= 1'b0;
      fr_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      dot_q  <= dot_d;
      x_q    <= x_d;
      vb_q   <= vb_d;
      lr_q   <= lr_d;
      fr_q   <= fr_d;
    end
  end

  seq_line_trk #(.TOTAL_LINES(TOTAL_LINES)) u_line (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (adv),
    .wrap_i    (wrap),
    .clr_i     (seq_clr),
    .lyc_i     (lyc_i),
    .ly_o      (ly),
    .ly_inc_o  (ly_inc),
    .next_eq_o (next_eq),
    .coinc_o   (coinc_o)
  );

  seq_win_ctr #(.W(LINE_W)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (win_inc),
    .clr_i  (win_clr | seq_clr),
    .cnt_o  (win_line_o)
  );

  seq_stat_irq #(.N(NUM_SRC)) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (ev),
    .en_i   (stat_en_i),
    .irq_o  (stat_irq_o)
  );

  assign mode_o       = mode_q;
  assign ly_o         = ly;
  assign dot_o        = dot_q;
  assign vblank_irq_o = vb_q;
  assign line_rst_o   = lr_q;
  assign frame_rst_o  = fr_q;

  // R3 R4 R6 R7 R9 R10
  mode_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_q) |->
      (($past(mode_q) == MODE_SCAN   && mode_q == MODE_DRAW) ||
       ($past(mode_q) == MODE_DRAW   && (mode_q == MODE_HBLANK || mode_q == MODE_SCAN)) ||
       ($past(mode_q) == MODE_HBLANK && (mode_q == MODE_SCAN || mode_q == MODE_VBLANK)) ||
       ($past(mode_q) == MODE_VBLANK && mode_q == MODE_SCAN)));

  // R4
  x_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x_q <= VIS_X);

  // R9
  vblank_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vb_q |-> (mode_q == MODE_VBLANK && ly == VIS_LY && frame_rst_o));

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dot_en_i |=> ($stable(dot_q) && $stable(mode_q) && !vb_q && !lr_q));
endmodule

// File: tb/scanline_seq_bench.sv
module scanline_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       dot_en, lcd_en, push, win_drawn;
  logic [7:0] lyc;
  logic [3:0] stat_en;
  logic [1:0] mode;
  logic [7:0] ly, win_line;
  logic [9:0] dot;
  logic       coinc, vb_irq, st_irq, line_rst, frame_rst;

  always #10 clk = ~clk;

  scanline_seq u_scanline_seq (
    .clk_i(clk), .rst_ni(rst_n), .dot_en_i(dot_en), .lcd_en_i(lcd_en),
    .px_push_i(push), .win_drawn_i(win_drawn), .lyc_i(lyc), .stat_en_i(stat_en),
    .mode_o(mode), .ly_o(ly), .dot_o(dot), .coinc_o(coinc), .win_line_o(win_line),
    .vblank_irq_o(vb_irq), .stat_irq_o(st_irq), .line_rst_o(line_rst),
    .frame_rst_o(frame_rst)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;

  int m_mode, m_dot, m_ly, m_coinc, m_win, m_x, m_vb, m_st, m_lr, m_fr;
  string m_tag;

  task automatic model_reset();
    m_mode = 2; m_dot = 0; m_ly = 0; m_coinc = 0; m_win = 0; m_x = 0;
    m_vb = 0; m_st = 0; m_lr = 0; m_fr = 0; m_tag = "R1";
  endtask

  task automatic model_step();
    int nd, nl, ev;
    ev = 0; m_vb = 0; m_lr = 0; m_fr = 0; m_tag = "R2";
    if (dot_en) begin
      nd = m_dot + 1;
      m_dot = nd;
      case (m_mode)
        2: if (nd >= 80) begin m_mode = 3; m_tag = "R3"; end
        3: begin
          if (m_x >= 160) begin
            m_x = 0; m_mode = 0; ev |= 1; m_lr = 1; m_tag = "R4";
            if (win_drawn) m_win = (m_win + 1) % 256;
          end else if (lcd_en) begin
            if (push) m_x++;
          end else begin
            m_mode = 2; m_dot = 0; m_x = 0; m_ly = 0; m_coinc = 0; m_win = 0;
            m_tag = "R6";
          end
        end
        0: if (nd >= 456) begin
          m_dot = nd - 456; nl = m_ly + 1;
          m_coinc = (nl == int'(lyc)) ? 1 : 0;
          if (m_coinc != 0) ev |= 8;
          m_ly = nl;
          if (nl >= 144) begin
            m_mode = 1; m_vb = 1; m_fr = 1; m_win = 0; ev |= 2; m_tag = "R9";
          end else begin
            m_mode = 2; ev |= 4; m_tag = "R7";
          end
        end
        default: if (nd > 456) begin
          m_dot = nd - 456; nl = m_ly + 1;
          m_coinc = (nl == int'(lyc)) ? 1 : 0;
          if (m_coinc != 0) ev |= 8;
          m_ly = nl; m_tag = "R10";
          if (nl == 154) begin m_ly = 0; m_mode = 2; ev |= 4; end
        end
      endcase
    end
    m_st = ((ev & int'(stat_en)) != 0) ? 1 : 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else        model_step();
  end

  task automatic chk(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      if (n_fail < 30)
        $display("FAIL %s %s act=%0d exp=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(m_tag, "mode", int'(mode), m_mode);
    chk(m_tag, "dot", int'(dot), m_dot);
    chk(m_tag, "ly", int'(ly), m_ly);
    chk("R8", "coinc", int'(coinc), m_coinc);
    chk("R5", "win_line", int'(win_line), m_win);
    chk("R11", "stat_irq", int'(st_irq), m_st);
    chk("R9", "vblank_irq", int'(vb_irq), m_vb);
    chk("R9", "frame_rst", int'(frame_rst), m_fr);
    chk("R4", "line_rst", int'(line_rst), m_lr);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int offs;
    void'($urandom(32'h5ca1_0042));
    rst_n = 1'b0; dot_en = 1'b0; lcd_en = 1'b1; push = 1'b0; win_drawn = 1'b0;
    lyc = 8'd3; stat_en = 4'hf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "mode", int'(mode), 2);
    chk("R1", "ly", int'(ly), 0);
    chk("R1", "dot", int'(dot), 0);
    chk("R1", "coinc", int'(coinc), 0);
    chk("R1", "win_line", int'(win_line), 0);
    chk("R1", "pulses", int'({vb_irq, st_irq, line_rst, frame_rst}), 0);
    // R2 idle clocks
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      compare_all();
    end
    chk("R2", "dot idle", int'(dot), 0);
    for (int i = 0; i < 90000; i++) begin
      dot_en    = ($urandom % 10) != 0;
      push      = ($urandom % 8) != 0;
      win_drawn = $urandom % 2;
      if (i % 5000 == 4999) stat_en = 4'($urandom);
      if (i > 3000 && i % 3000 == 0) lyc = 8'($urandom % 156);
      if (i == 76000) begin lyc = 8'd154; stat_en = 4'hf; end
      @(negedge clk);
      compare_all();
    end
    // R6 display off during drawing
    offs = 0;
    for (int i = 0; i < 6000 && offs < 3; i++) begin
      if (m_mode == 3 && m_x < 150 && m_dot > 90) begin
        dot_en = 1'b1; lcd_en = 1'b0;
        @(negedge clk);
        compare_all();
        chk("R6", "mode off", int'(mode), 2);
        chk("R6", "dot off", int'(dot), 0);
        chk("R6", "ly off", int'(ly), 0);
        chk("R6", "stat off", int'(st_irq), 0);
        lcd_en = 1'b1;
        offs++;
      end else begin
        dot_en = 1'b1;
        push   = ($urandom % 8) != 0;
        @(negedge clk);
        compare_all();
      end
    end
    chk("R6", "events", offs, 3);
    done = 1;
    summary();
    $finish;
  end
endmodule